// File: doc/BRIEF.md
# Interlocked Handshake Debug Register Target

This block is the system-clock side of a small debug register bus. A master raises a request strobe and, in the same cycle, presents an address, write data and a write flag. The target captures them on that edge, performs the access once, and answers on the next cycle with an acknowledge and, for reads, the read data. Both stay put until the master drops its request. The target then lowers acknowledge, and the handshake is complete.

Behind the handshake sits a small register bank. A parameterised number of read/write scratch registers starts at address zero. A read-only identification word and a free-running cycle counter sit at two further addresses, both set by parameters. Every other address reads as zero. A request may stay high for any length of time: the target neither repeats the access nor changes its answer while it waits.

Top module: `dbg_reg_target`

## Requirements
- R1: When the target is idle (acknowledge low) and `req_i` is sampled high on a clock edge, `ack_o` is high from the following cycle.
- R2: While `req_i` stays high, `ack_o` stays high for any number of cycles. There is no timeout.
- R3: While `ack_o` is high, `rdata_o` does not change. While `ack_o` is low, `rdata_o` is zero.
- R4: A write is applied exactly once, on the edge where the request is accepted. While acknowledge is held, changes to `addr_i`, `wdata_i` and `wr_i` have no effect on any register. A write answers with `rdata_o` equal to zero.
- R5: On the edge that samples `req_i` low while `ack_o` is high, `ack_o` falls. A new request raised one cycle after acknowledge is seen low is accepted.
- R6: Addresses 0 to NUM_RW-1 (default 0 to 3) are read/write registers, and a read returns the last value written there.
- R7: Address ID_ADDR (default 0x10) reads as ID_VALUE (default 0x5EED0001). Writes to it are acknowledged and ignored.
- R8: Address CNT_ADDR (default 0x11) reads the cycle counter: the number of clock edges since reset was released, as sampled on the accepting edge. Writes to it are acknowledged and ignored.
- R9: Reads of any other address return zero. Writes to any other address are acknowledged and change nothing.
- R10: A synchronous active-high `rst` clears `ack_o`, `rdata_o`, the read/write registers and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe from the master |
| addr_i | input | AW | Register address, valid with the rising request |
| wdata_i | input | DW | Write data, valid with the rising request |
| wr_i | input | 1 | 1 = write, 0 = read |
| ack_o | output | 1 | Acknowledge, held until the request falls |
| rdata_o | output | DW | Read data, held while acknowledge is high |

## Verification
A state machine stuck in the wrong state shows on the very next edge. Either `ack_o` fails to rise after an idle request, or it fails to fall one cycle after the request drops. A write that repeats while the request is held leaves no mark at once; it shows on the next read of that register, after the master scribbled new data onto the bus during the hold. A read value sampled live instead of at acceptance shows as `rdata_o` changing during a held acknowledge when the counter is read.

// File: rtl/dbg_reg_target.sv
module dbg_reg_target #(
  parameter int          AW       = 8,
  parameter int          DW       = 32,
  parameter int          NUM_RW   = 4,
  parameter logic [7:0]  ID_ADDR  = 8'h10,
  parameter logic [7:0]  CNT_ADDR = 8'h11,
  parameter logic [31:0] ID_VALUE = 32'h5EED_0001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o
);

  localparam logic [AW-1:0] IdA  = AW'(ID_ADDR);
  localparam logic [AW-1:0] CntA = AW'(CNT_ADDR);
  localparam logic [DW-1:0] IdV  = DW'(ID_VALUE);

  typedef enum logic {ST_IDLE, ST_ACK} st_t;

  st_t                       st_q;
  logic [NUM_RW-1:0][DW-1:0] rw_q;
  logic [DW-1:0]             cnt_q;
  logic [DW-1:0]             rd_val;
  logic                      accept;

  assign accept = (st_q == ST_IDLE) && req_i;

  // free-running cycle counter
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // scratch registers, written only on the accepting edge
  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    always_ff @(posedge clk) begin
      if (rst)
        rw_q[g] <= '0;
      else if (accept && wr_i && addr_i == AW'(g))
        rw_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (addr_i == AW'(i)) rd_val = rw_q[i];
    if (addr_i == IdA)  rd_val = IdV;
    if (addr_i == CntA) rd_val = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_i) begin
          st_q    <= ST_ACK;
          ack_o   <= 1'b1;
          rdata_o <= wr_i ? '0 : rd_val;
        end
        default: if (!req_i) begin
          st_q    <= ST_IDLE;
          ack_o   <= 1'b0;
          rdata_o <= '0;
        end
      endcase
    end
  end

  // R1
  ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack_o && req_i) |=> ack_o);
  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && req_i) |=> ack_o);
  // R3
  rdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && req_i) |=> $stable(rdata_o));
  // R3
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_o |-> (rdata_o == '0));
  // R4
  one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && req_i) |=> $stable(rw_q));
  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && !req_i) |=> !ack_o);

endmodule

// File: tb/dbg_reg_target_tb_top.sv
module dbg_reg_target_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic        ack;
  logic [31:0] rdata;

  int n_chk = 0, n_bad = 0;
  logic [31:0] tb_cyc = '0;
  logic [31:0] model [4];

  always #10 clk = ~clk;

  always @(posedge clk) tb_cyc <= rst ? 32'd0 : tb_cyc + 32'd1;

  dbg_reg_target dut_i (
    .clk(clk), .rst(rst), .req_i(req), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .ack_o(ack), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [31:0] c);
    if (a < 8'd4)  return model[a[1:0]];
    if (a == 8'h10) return 32'h5EED_0001;
    if (a == 8'h11) return c;
    return 32'd0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a < 8'd4)   return "R6 rw";
    if (a == 8'h10) return "R7 id";
    if (a == 8'h11) return "R8 counter";
    return "R9 unmapped";
  endfunction

  task automatic xact(input logic [7:0] a, input logic w, input logic [31:0] d,
                      input int hold, input int gap);
    logic [31:0] e;
    @(negedge clk);
    req = 1'b1; addr = a; wr = w; wdata = d;
    e = w ? 32'd0 : exp_read(a, tb_cyc);
    if (w && a < 8'd4) model[a[1:0]] = d;
    @(negedge clk);
    chk("R1 ack after request", {31'd0, ack}, 32'd1);
    chk(w ? "R4 write rdata" : tag_of(a), rdata, e);
    for (int i = 0; i < hold; i++) begin
      wdata = $urandom; wr = 1'b1;
      if ($urandom % 2) addr = 8'($urandom % 4);
      @(negedge clk);
      chk("R2 ack held", {31'd0, ack}, 32'd1);
      chk("R3 rdata held", rdata, e);
    end
    req = 1'b0; wr = $urandom; wdata = $urandom; addr = $urandom;
    @(negedge clk);
    chk("R5 ack drop", {31'd0, ack}, 32'd0);
    chk("R3 rdata zero when idle", rdata, 32'd0);
    repeat (gap) @(negedge clk);
  endtask

  function automatic logic [7:0] pick_addr();
    case ($urandom % 6)
      0, 1:    return 8'($urandom % 4);
      2:       return 8'h10;
      3:       return 8'h11;
      default: return 8'($urandom % 240) + 8'h12;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ack after reset", {31'd0, ack}, 32'd0);
    chk("R10 rdata after reset", rdata, 32'd0);
    xact(8'h02, 1'b0, '0, 0, 0);

    // R4: one-shot write under a long held request with scribbled bus
    xact(8'h01, 1'b1, 32'hCAFE_0001, 12, 0);
    xact(8'h01, 1'b0, '0, 3, 0);
    // R7 / R8 / R9: writes ignored, acknowledged
    xact(8'h10, 1'b1, 32'hFFFF_FFFF, 1, 0);
    xact(8'h10, 1'b0, '0, 0, 0);
    xact(8'h11, 1'b1, 32'h0, 0, 0);
    xact(8'h11, 1'b0, '0, 6, 0);
    xact(8'h7F, 1'b1, 32'h1234_5678, 0, 0);
    xact(8'h7F, 1'b0, '0, 0, 0);
    xact(8'hFF, 1'b0, '0, 2, 0);
    // R5: back-to-back at the minimum gap
    for (int i = 0; i < 4; i++) xact(8'(i), 1'b1, 32'hA000_0000 + 32'(i), 0, 0);
    for (int i = 0; i < 4; i++) xact(8'(i), 1'b0, '0, 0, 0);

    for (int n = 0; n < 300; n++)
      xact(pick_addr(), 1'($urandom), $urandom, int'($urandom % 5), int'($urandom % 3));

    // R10: reset in mid-run clears registers and counter
    @(negedge clk); rst = 1'b1;
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R10 ack in reset", {31'd0, ack}, 32'd0);
    for (int i = 0; i < 4; i++) xact(8'(i), 1'b0, '0, 0, 0);
    xact(8'h11, 1'b0, '0, 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule